// File: doc/BRIEF.md
# Daisy-Chainable Serial Attenuator Controller

This block is the digital control front end of a multi-channel stepped attenuator. A 16-bit command frame arrives serially, most significant bit first, one bit per cycle in which `bit_valid` is high. The bit displaced from the far end of the shift register is driven on `sdo`, so the serial output of one block can feed the serial input of the next and a whole chain can share a single data line and a single load line.

A rising edge on the asynchronous `load` line is first synchronised and then detected. On that edge the frame held in the shift register is taken as an 8-bit channel address in the upper byte and an 8-bit attenuation code in the lower byte. Only the addressed channel takes the new code. Each channel then decodes its code into a one-hot tap-select vector and a mute flag. Codes 0x00 to 0x7F pick taps 0 to 127. Codes 0x80 to 0xFD are clamped to the last tap. Codes 0xFE and 0xFF mute the channel. After reset every channel is muted.

Top module: `serial_atten_ctrl`

## Requirements
- R1: A frame is 16 bits entered MSB first; on a latch, bits 15..8 are taken as the channel address and bits 7..0 as the attenuation code.
- R2: Each shift drives on `sdo` the bit pushed out of bit 15 of the shift register, so that during the next 16 shifts the previous frame leaves on `sdo` MSB first. `sdo` holds its value in cycles with no shift.
- R3: Bits are shifted only while the synchronised `load` is low. `bit_valid` pulses while `load` is high leave the shift register unchanged. A latch happens only on a rising edge of `load`.
- R4: A latch updates only the addressed channel. Every other channel keeps its code and outputs.
- R5: An address of 2 or above names no channel, and a latch with such an address changes no output.
- R6: A code from 0x00 to 0x7F drives exactly tap-select bit `code` of that channel and clears its mute flag.
- R7: A code from 0x80 to 0xFD drives only tap-select bit 127 of that channel and clears its mute flag.
- R8: Codes 0xFE and 0xFF set the channel's mute flag and drive all of its tap-select bits to zero.
- R9: While reset is asserted, and after it is released, every channel is muted with no tap selected.
- R10: Outputs do not change while bits are shifted. They take their new value within four clock cycles after `load` rises, and not in the first cycle after it rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset; mutes all channels |
| bit_valid | input | 1 | Shift strobe: take `sdi` this cycle |
| sdi | input | 1 | Serial data in, MSB first |
| load | input | 1 | Asynchronous load/shift line; its rising edge latches the frame |
| sdo | output | 1 | Serial data out for chaining (displaced bit) |
| tap_sel | output | 256 | One-hot tap select, channel n at bits n*128 +: 128 |
| mute | output | 2 | Per-channel mute flag |

## Verification
The bench targets the boundaries of the code map. These are 0x7F against 0x80, 0xFD against 0xFE, and 0xFF. A wrong comparison there would light a tap on a muted channel or leave a channel silent where it should clamp. It sends frames to addresses 2 and above, and a decoder that wraps or truncates the address would then overwrite a real channel. It pulses `bit_valid` while `load` is high and re-latches. A shifter that ignores the gate would corrupt the stored frame and the bits later seen on `sdo`. It also checks the outputs one cycle after `load` rises, to catch a design that bypasses the synchroniser. The chain output is compared bit by bit against the previously sent frame, which exposes an off-by-one or LSB-first shift.

// File: rtl/atten_pkg.sv
package atten_pkg;

   // Classification of an attenuation code
   typedef enum logic [1:0] {
      CLS_FINE   = 2'd0,
      CLS_COARSE = 2'd1,
      CLS_MUTE   = 2'd2
   } code_cls_e;

endpackage

// File: rtl/atten_shift.sv
module atten_shift #(
   parameter int unsigned FRAME_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               shift,
   input  logic               sdi,
   output logic [FRAME_W-1:0] frame,
   output logic               sdo
);

   logic [FRAME_W-1:0] sreg_q;
   logic               sdo_q;

   if (FRAME_W < 2) begin : g_bad_w
      $error("atten_shift: FRAME_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg_q <= '0;
         sdo_q  <= 1'b0;
      end else if (shift) begin
         sreg_q <= {sreg_q[FRAME_W-2:0], sdi};
         sdo_q  <= sreg_q[FRAME_W-1];
      end
   end

   assign frame = sreg_q;
   assign sdo   = sdo_q;

   // R2
   sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !shift |=> $stable(sdo));

   // R2
   sdo_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shift |=> (sdo == $past(frame[FRAME_W-1])));

endmodule

// File: rtl/atten_edge_sync.sv
module atten_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic level,
   output logic rise
);

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("atten_edge_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_in};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign level = chain_q[STAGES-1];
   assign rise  = level & ~prev_q;

   // R10
   rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);

endmodule

// File: rtl/atten_chan.sv
module atten_chan
   import atten_pkg::*;
#(
   parameter int unsigned CODE_W    = 8,
   parameter int unsigned NUM_TAPS  = 128,
   parameter int unsigned MUTE_CODE = 254,
   parameter bit          REG_OUT   = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [CODE_W-1:0]   wr_code,
   output logic [NUM_TAPS-1:0] tap_sel,
   output logic                mute
);

   localparam int unsigned TAP_W = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1;
   localparam logic [CODE_W-1:0] LAST_FINE = CODE_W'(NUM_TAPS - 1);
   localparam logic [CODE_W-1:0] MUTE_C    = CODE_W'(MUTE_CODE);
   localparam logic [TAP_W-1:0]  LAST_TAP  = TAP_W'(NUM_TAPS - 1);

   if (NUM_TAPS > (1 << CODE_W)) begin : g_bad_taps
      $error("atten_chan: NUM_TAPS exceeds code space");
   end
   if (MUTE_CODE < NUM_TAPS || MUTE_CODE >= (1 << CODE_W)) begin : g_bad_mute
      $error("atten_chan: MUTE_CODE must lie above the fine range");
   end

   logic [CODE_W-1:0]   code_q;
   code_cls_e           cls;
   logic [TAP_W-1:0]    tap_idx;
   logic [NUM_TAPS-1:0] dec_taps;
   logic                dec_mute;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '1;
      end else if (wr_en) begin
         code_q <= wr_code;
      end
   end

   always_comb begin
      if (code_q >= MUTE_C) begin
         cls = CLS_MUTE;
      end else if (code_q > LAST_FINE) begin
         cls = CLS_COARSE;
      end else begin
         cls = CLS_FINE;
      end
   end

   always_comb begin
      tap_idx  = LAST_TAP;
      dec_taps = '0;
      dec_mute = 1'b0;
      unique case (cls)
         CLS_FINE: begin
            tap_idx           = code_q[TAP_W-1:0];
            dec_taps[tap_idx] = 1'b1;
         end
         CLS_COARSE: begin
            dec_taps[LAST_TAP] = 1'b1;
         end
         default: begin
            dec_mute = 1'b1;
         end
      endcase
   end

   if (REG_OUT) begin : g_reg_out
      logic [NUM_TAPS-1:0] taps_q;
      logic                mute_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            taps_q <= '0;
            mute_q <= 1'b1;
         end else begin
            taps_q <= dec_taps;
            mute_q <= dec_mute;
         end
      end
      assign tap_sel = taps_q;
      assign mute    = mute_q;
   end else begin : g_comb_out
      assign tap_sel = dec_taps;
      assign mute    = dec_mute;
   end

   // R8
   mute_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mute |-> (tap_sel == '0));

   // R6
   tap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mute |-> $onehot(tap_sel));

   // R4
   code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(code_q));

endmodule

// File: rtl/serial_atten_ctrl.sv
module serial_atten_ctrl #(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned CODE_W      = 8,
   parameter int unsigned NUM_CH      = 2,
   parameter int unsigned NUM_TAPS    = 128,
   parameter int unsigned MUTE_CODE   = 254,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          REG_OUT     = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bit_valid,
   input  logic                       sdi,
   input  logic                       load,
   output logic                       sdo,
   output logic [NUM_CH*NUM_TAPS-1:0] tap_sel,
   output logic [NUM_CH-1:0]          mute
);

   localparam int unsigned FRAME_W = ADDR_W + CODE_W;

   if (NUM_CH < 1 || NUM_CH > (1 << ADDR_W)) begin : g_bad_ch
      $error("serial_atten_ctrl: NUM_CH out of address range");
   end

   logic [FRAME_W-1:0] frame;
   logic [ADDR_W-1:0]  frm_addr;
   logic [CODE_W-1:0]  frm_code;
   logic               load_level;
   logic               load_rise;
   logic               do_shift;
   logic [NUM_CH-1:0]  wr_vec;

   atten_edge_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (load),
      .level    (load_level),
      .rise     (load_rise)
   );

   assign do_shift = bit_valid & ~load_level;

   atten_shift #(
      .FRAME_W (FRAME_W)
   ) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .shift (do_shift),
      .sdi   (sdi),
      .frame (frame),
      .sdo   (sdo)
   );

   assign frm_addr = frame[FRAME_W-1 -: ADDR_W];
   assign frm_code = frame[CODE_W-1:0];

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      assign wr_vec[ch] = load_rise && (frm_addr == ADDR_W'(ch));

      atten_chan #(
         .CODE_W    (CODE_W),
         .NUM_TAPS  (NUM_TAPS),
         .MUTE_CODE (MUTE_CODE),
         .REG_OUT   (REG_OUT)
      ) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr_vec[ch]),
         .wr_code (frm_code),
         .tap_sel (tap_sel[ch*NUM_TAPS +: NUM_TAPS]),
         .mute    (mute[ch])
      );
   end

   // R5
   sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_vec));

   // R3
   shift_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_level |=> $stable(frame));

   // R10
   idle_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_level && !$past(load_level)) |=> $stable(mute));

endmodule

// File: tb/tb_serial_atten_ctrl.sv
module tb_serial_atten_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int NTAP       = 128;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            bit_valid;
   logic            sdi;
   logic            load;
   logic            sdo;
   logic [2*NTAP-1:0] tap_sel;
   logic [1:0]      mute;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [7:0]  exp_code [2];
   logic [15:0] sreg_model;

   always #(CLK_PERIOD/2) clk = ~clk;

   serial_atten_ctrl dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_valid (bit_valid),
      .sdi       (sdi),
      .load      (load),
      .sdo       (sdo),
      .tap_sel   (tap_sel),
      .mute      (mute)
   );

   function automatic logic [NTAP-1:0] exp_taps(input logic [7:0] c);
      logic [NTAP-1:0] v;
      v = '0;
      if (c >= 8'hFE)      v = '0;
      else if (c >= 8'h80) v[NTAP-1] = 1'b1;
      else                 v[c[6:0]] = 1'b1;
      return v;
   endfunction

   task automatic check_outputs(input string req);
      logic [2*NTAP-1:0] et;
      logic [1:0]        em;
      et = {exp_taps(exp_code[1]), exp_taps(exp_code[0])};
      em = {exp_code[1] >= 8'hFE, exp_code[0] >= 8'hFE};
      checks++;
      if (tap_sel !== et || mute !== em) begin
         errors++;
         $display("FAIL %s: tap_sel=%h mute=%b expected tap_sel=%h mute=%b",
                  req, tap_sel, mute, et, em);
      end
   endtask

   task automatic send_frame(input logic [7:0] addr, input logic [7:0] code,
                             input string req);
      logic [15:0] fr;
      int          bad;
      fr  = {addr, code};
      bad = 0;
      load = 1'b0;
      repeat (4) @(negedge clk);
      for (int k = 0; k < 16; k++) begin
         @(negedge clk);
         if (k > 0 && sdo !== sreg_model[16-k]) bad++;
         sdi       = fr[15-k];
         bit_valid = 1'b1;
      end
      @(negedge clk);
      if (sdo !== sreg_model[0]) bad++;
      bit_valid = 1'b0;
      checks++;
      if (bad != 0) begin
         errors++;
         $display("FAIL R2: %0d sdo bits differ from previous frame %h", bad, sreg_model);
      end
      sreg_model = fr;
      // R10: nothing changes during shifting or one cycle after load rises
      check_outputs("R10 (hold during shift)");
      load = 1'b1;
      @(negedge clk);
      check_outputs("R10 (no change one cycle after load)");
      repeat (4) @(negedge clk);
      if (addr < 8'd2) exp_code[addr[0]] = code;
      check_outputs(req);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      rst_n     = 1'b0;
      bit_valid = 1'b0;
      sdi       = 1'b0;
      load      = 1'b0;
      sreg_model = '0;
      exp_code[0] = 8'hFF;
      exp_code[1] = 8'hFF;
      repeat (3) @(negedge clk);
      // R9 during reset
      check_outputs("R9 (in reset)");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check_outputs("R9 (after reset)");

      // R1 R4 R6: fine range ends
      send_frame(8'd0, 8'h00, "R6 R1 R4 ch0 code 0x00");
      send_frame(8'd1, 8'h7F, "R6 R1 R4 ch1 code 0x7F");
      send_frame(8'd0, 8'h41, "R6 ch0 code 0x41");
      // R7: coarse clamp boundaries
      send_frame(8'd0, 8'h80, "R7 ch0 code 0x80");
      send_frame(8'd1, 8'hFD, "R7 ch1 code 0xFD");
      // R8: mute codes
      send_frame(8'd1, 8'hFE, "R8 ch1 code 0xFE");
      send_frame(8'd0, 8'hFF, "R8 ch0 code 0xFF");
      send_frame(8'd0, 8'h12, "R6 ch0 code 0x12");
      send_frame(8'd1, 8'h05, "R6 ch1 code 0x05");
      // R5: addresses naming no channel
      send_frame(8'd2,   8'h33, "R5 address 2 ignored");
      send_frame(8'hFF,  8'hFE, "R5 address 0xFF ignored");
      send_frame(8'h80,  8'h00, "R5 address 0x80 ignored");

      // R3: strobes while load high are ignored; re-latch keeps the code
      send_frame(8'd0, 8'h22, "R3 ch0 code 0x22");
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         sdi       = 1'($urandom);
         bit_valid = 1'b1;
      end
      @(negedge clk);
      bit_valid = 1'b0;
      load      = 1'b0;
      repeat (4) @(negedge clk);
      load = 1'b1;
      repeat (5) @(negedge clk);
      check_outputs("R3 re-latch after gated strobes");

      // Random frames mixed across code regions
      for (int n = 0; n < 60; n++) begin
         logic [7:0] a;
         logic [7:0] c;
         a = 8'($urandom_range(0, 3));
         case ($urandom % 4)
            0:       c = 8'($urandom_range(0, 127));
            1:       c = 8'($urandom_range(128, 253));
            2:       c = 8'($urandom_range(254, 255));
            default: c = 8'($urandom);
         endcase
         send_frame(a, c, "R4 random frame");
      end

      // R9: reset from a non-muted state
      send_frame(8'd1, 8'h10, "R6 ch1 code 0x10");
      @(negedge clk);
      rst_n = 1'b0;
      exp_code[0] = 8'hFF;
      exp_code[1] = 8'hFF;
      @(negedge clk);
      check_outputs("R9 (reset after use)");
      rst_n = 1'b1;

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish, actual running expected done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule